// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Recognition

This block turns an asynchronous serial line into received characters. It runs on the system clock. A one-cycle enable pulse arrives sixteen times per bit period. The block waits for a falling edge and checks that the line is still low in the middle of the start bit. It then collects 8 or 9 data bits, least significant first. An optional parity bit follows, and last comes the stop position. Each bit is taken as a three-sample majority around the bit centre.

After each completed character the block raises a receiver-full indication and reports four error conditions: framing, parity, overrun and noise. A character that is zero from the first data bit through the stop position, with any parity position also zero, counts as a line break. For a break the stored data and ninth bit are forced to zero and a dedicated break flag is raised, together with the framing error and receiver-full. A single clear strobe acknowledges the character, either when software reads it or when it clears the flags. Baud generation, register decoding and interrupt logic sit outside this block.

The sixteen tick positions of a bit are counted from 1. Tick 1 is the tick on which the falling edge of the start bit is first seen.

Top module: `serial_rx_break`

## Requirements
- R1: Data bits are received least significant bit first. With `cfg_nine`=0 the block takes 8 data bits into `rx_data`, and `rx_bit8` is 0. With `cfg_nine`=1 the block takes 9 data bits, and the last one goes to `rx_bit8`. `rx_full` rises once the stop position has been sampled.
- R2: Each bit is resolved by a majority vote over the line values at ticks 8, 9 and 10 of that bit. If the three samples disagree anywhere in the character, `err_noise` is set. A disturbance outside those three ticks has no effect.
- R3: A character starts only when the line is seen to fall from high to low and the vote at mid start bit is low. A low pulse that is gone by mid-bit returns the receiver to idle, and nothing is reported.
- R4: A stop position sampled as 0 in a character that is not a break sets `err_frame`. The data is still stored, and `brk_flag` stays 0.
- R5: A character is a break when all its data bits are 0, the parity position (if enabled) is 0 and the stop position is 0. A break sets `rx_full`, `err_frame` and `brk_flag`, and forces `rx_data` and `rx_bit8` to 0.
- R6: With `cfg_par_en`=1 one parity bit follows the data bits. With `cfg_par_odd`=0 the data bits and the parity bit must hold an even number of ones; with `cfg_par_odd`=1, an odd number. A mismatch sets `err_parity`, and this rule also applies to a break.
- R7: A character that completes while `rx_full` is still 1 sets `err_overrun`. The stored data, ninth bit and the other flags keep their values.
- R8: A one-cycle `clr_strobe` clears `rx_full` and all five flags but leaves `rx_data` as it was. No flag is ever 1 while `rx_full` is 0.
- R9: After a break the receiver accepts no new character until the line has returned high and then fallen again.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, sixteen pulses per bit |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| clr_strobe | input | 1 | Acknowledge: clears full and all flags |
| rx_data | output | 8 | Received data bits 0 to 7 |
| rx_bit8 | output | 1 | Ninth received data bit |
| rx_full | output | 1 | A character is waiting |
| err_frame | output | 1 | Stop position sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Character lost because the receiver was full |
| err_noise | output | 1 | Sample disagreement inside a bit |
| brk_flag | output | 1 | The character was a break |

## Verification
The vector table covers several groups of characters:
- Mixed bit patterns in 8- and 9-bit form, which separate bit order and ninth-bit placement.
- Even and odd parity, which show whether parity is counted over the right bits.
- All-zero characters that are nearly breaks: a good stop, or a single high ninth bit. These separate a true break from a plain framing error or a zero byte.
- Breaks under odd and even parity, which show parity being judged by its normal rule during a break.

Directed runs add further cases:
- A glitch inside and a glitch outside the sampling window, which shows exactly where the vote looks.
- A short low pulse, which shows start validation.
- A second character arriving while the receiver is full.
- A line held low long after a break, which shows that a new character needs a high-to-low transition.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         $error("srx_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/srx_vote.sv
module srx_vote
   import srx_pkg::*;
#(
   parameter int OS_RATE = 16,
   parameter int CW      = $clog2(OS_RATE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          busy,
   input  logic [CW-1:0] os_cnt,
   input  logic          rx,
   output logic          vote_ok,
   output logic          bit_val,
   output logic          bit_noisy
);

   localparam int MID = OS_RATE / 2;

   generate
      if (OS_RATE < 4) begin : g_bad
         $error("srx_vote: OS_RATE must be at least 4");
      end
   endgenerate

   logic s_a, s_b;
   logic take_a, take_b;

   assign take_a  = tick && busy && (os_cnt == CW'(MID - 1));
   assign take_b  = tick && busy && (os_cnt == CW'(MID));
   assign vote_ok = tick && busy && (os_cnt == CW'(MID + 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_a <= 1'b1;
         s_b <= 1'b1;
      end else begin
         if (take_a) s_a <= rx;
         if (take_b) s_b <= rx;
      end
   end

   assign bit_val   = maj3(s_a, s_b, rx);
   assign bit_noisy = !((s_a == s_b) && (s_b == rx));

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OS_RATE    = 16,
   parameter int DATA_W     = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              cfg_nine,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   output logic              frame_done,
   output logic [DATA_W-1:0] f_data,
   output logic              f_bit8,
   output logic              f_stop,
   output logic              f_noisy,
   output logic              f_par_bad,
   output logic              f_break
);

   localparam int CW      = $clog2(OS_RATE);
   localparam int FRAME_W = DATA_W + 1;
   localparam int IW      = $clog2(FRAME_W + 1);

   rx_state_e         state;
   logic [CW-1:0]     os_cnt;
   logic [IW-1:0]     bit_idx;
   logic [FRAME_W-1:0] shreg;
   logic              par_bit, noisy, rx_prev;
   logic              vote_ok, bit_val, bit_noisy;
   logic              par_on;
   logic              edge_seen, bit_end;
   logic [IW-1:0]     last_idx;

   assign edge_seen = tick && rx_prev && !rx;
   assign bit_end   = tick && (os_cnt == CW'(OS_RATE - 1));
   assign last_idx  = cfg_nine ? IW'(FRAME_W - 1) : IW'(DATA_W - 1);

   srx_vote #(.OS_RATE(OS_RATE), .CW(CW)) u_vote (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .busy     (state != ST_IDLE),
      .os_cnt   (os_cnt),
      .rx       (rx),
      .vote_ok  (vote_ok),
      .bit_val  (bit_val),
      .bit_noisy(bit_noisy)
   );

   generate
      if (HAS_PARITY) begin : g_par
         assign par_on    = cfg_par_en;
         assign f_par_bad = par_on && ((^shreg) ^ par_bit ^ cfg_par_odd);
      end else begin : g_nopar
         logic unused_par_cfg;
         assign unused_par_cfg = cfg_par_en ^ cfg_par_odd;
         assign par_on    = 1'b0;
         assign f_par_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         os_cnt  <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         noisy   <= 1'b0;
         rx_prev <= 1'b1;
      end else begin
         if (tick) rx_prev <= rx;
         if (tick && state != ST_IDLE)
            os_cnt <= bit_end ? '0 : os_cnt + 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (edge_seen) begin
                  state   <= ST_START;
                  os_cnt  <= CW'(1);
                  bit_idx <= '0;
                  shreg   <= '0;
                  par_bit <= 1'b0;
                  noisy   <= 1'b0;
               end
            end
            ST_START: begin
               if (vote_ok) begin
                  if (bit_val) state <= ST_IDLE;
                  else         noisy <= bit_noisy;
               end
               if (bit_end) state <= ST_DATA;
            end
            ST_DATA: begin
               if (vote_ok) begin
                  shreg <= shreg | (FRAME_W'(bit_val) << bit_idx);
                  noisy <= noisy | bit_noisy;
               end
               if (bit_end) begin
                  if (bit_idx == last_idx) state <= par_on ? ST_PAR : ST_STOP;
                  else                     bit_idx <= bit_idx + 1'b1;
               end
            end
            ST_PAR: begin
               if (vote_ok) begin
                  par_bit <= bit_val;
                  noisy   <= noisy | bit_noisy;
               end
               if (bit_end) state <= ST_STOP;
            end
            ST_STOP: begin
               if (vote_ok) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign frame_done = (state == ST_STOP) && vote_ok;
   assign f_data     = shreg[DATA_W-1:0];
   assign f_bit8     = shreg[DATA_W];
   assign f_stop     = bit_val;
   assign f_noisy    = noisy | bit_noisy;
   assign f_break    = (shreg == '0) && !(par_on && par_bit) && !bit_val;

   // R3: a high mid-start vote sends the receiver back to idle
   p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && vote_ok && bit_val) |=> (state == ST_IDLE));

   // R3, R9: a character only begins on a seen high-to-low transition
   p_edge_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && $past(state) == ST_IDLE) |-> $past(tick && rx_prev && !rx));

endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              done,
   input  logic [DATA_W-1:0] f_data,
   input  logic              f_bit8,
   input  logic              f_stop,
   input  logic              f_noisy,
   input  logic              f_par_bad,
   input  logic              f_break,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit8,
   output logic              rx_full,
   output logic              err_frame,
   output logic              err_parity,
   output logic              err_overrun,
   output logic              err_noise,
   output logic              brk_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_bit8     <= 1'b0;
         rx_full     <= 1'b0;
         err_frame   <= 1'b0;
         err_parity  <= 1'b0;
         err_overrun <= 1'b0;
         err_noise   <= 1'b0;
         brk_flag    <= 1'b0;
      end else begin
         if (clr) begin
            rx_full     <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            err_noise   <= 1'b0;
            brk_flag    <= 1'b0;
         end
         if (done) begin
            if (rx_full && !clr) begin
               err_overrun <= 1'b1;
            end else begin
               rx_full    <= 1'b1;
               rx_data    <= f_break ? '0 : f_data;
               rx_bit8    <= f_bit8 && !f_break;
               err_frame  <= !f_stop;
               err_parity <= f_par_bad;
               err_noise  <= f_noisy;
               brk_flag   <= f_break;
            end
         end
      end
   end

   // R5: a reported break always carries zero data and a framing error
   p_break_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_flag |-> (rx_data == '0 && !rx_bit8 && err_frame && rx_full));

   // R8: flags only exist alongside a waiting character
   p_flags_need_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frame || err_parity || err_overrun || err_noise || brk_flag) |-> rx_full);

   // R7: while full and unacknowledged, stored data does not move
   p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !clr) |=> ($stable(rx_data) && $stable(rx_bit8)));

   // R8: acknowledge empties the receiver
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !done) |=> !rx_full);

endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break #(
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter bit HAS_PARITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_line,
   input  logic              cfg_nine,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              clr_strobe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit8,
   output logic              rx_full,
   output logic              err_frame,
   output logic              err_parity,
   output logic              err_overrun,
   output logic              err_noise,
   output logic              brk_flag
);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("serial_rx_break: DATA_W must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              frame_done;
   logic [DATA_W-1:0] f_data;
   logic              f_bit8, f_stop, f_noisy, f_par_bad, f_break;

   srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (rx_line),
      .q    (rx_s)
   );

   srx_framer #(.OS_RATE(OS_RATE), .DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (os_tick),
      .rx         (rx_s),
      .cfg_nine   (cfg_nine),
      .cfg_par_en (cfg_par_en),
      .cfg_par_odd(cfg_par_odd),
      .frame_done (frame_done),
      .f_data     (f_data),
      .f_bit8     (f_bit8),
      .f_stop     (f_stop),
      .f_noisy    (f_noisy),
      .f_par_bad  (f_par_bad),
      .f_break    (f_break)
   );

   srx_status #(.DATA_W(DATA_W)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_strobe),
      .done       (frame_done),
      .f_data     (f_data),
      .f_bit8     (f_bit8),
      .f_stop     (f_stop),
      .f_noisy    (f_noisy),
      .f_par_bad  (f_par_bad),
      .f_break    (f_break),
      .rx_data    (rx_data),
      .rx_bit8    (rx_bit8),
      .rx_full    (rx_full),
      .err_frame  (err_frame),
      .err_parity (err_parity),
      .err_overrun(err_overrun),
      .err_noise  (err_noise),
      .brk_flag   (brk_flag)
   );

   // R1: in 8-bit form a newly stored character has no ninth bit
   p_short_no_bit8_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_nine && $rose(rx_full)) |-> !rx_bit8);

endmodule

// File: tb/test_serial_rx_break.sv
module test_serial_rx_break;

   logic       clk = 1'b0;
   logic       rst_n, os_tick, rx_line, cfg_nine, cfg_par_en, cfg_par_odd, clr_strobe;
   logic [7:0] rx_data;
   logic       rx_bit8, rx_full, err_frame, err_parity, err_overrun, err_noise, brk_flag;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   serial_rx_break i_serial_rx_break (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
      .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .clr_strobe(clr_strobe), .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
      .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
      .err_noise(err_noise), .brk_flag(brk_flag)
   );

   typedef struct packed {
      logic       nine;
      logic       pen;
      logic       podd;
      logic       parbit;
      logic [8:0] dat;
      logic       stop;
      logic [7:0] e_dat;
      logic       e_r8;
      logic       e_fe;
      logic       e_pe;
      logic       e_brk;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b0,1'b0,9'h055,1'b1,8'h55,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b0,1'b0,9'h0A3,1'b1,8'hA3,1'b0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,9'h1C4,1'b1,8'hC4,1'b1,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,9'h07F,1'b1,8'h7F,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b1,1'b0,1'b0,9'h00F,1'b1,8'h0F,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b1,1'b0,1'b0,9'h007,1'b1,8'h07,1'b0,1'b0,1'b1,1'b0},
      '{1'b0,1'b1,1'b1,1'b0,9'h007,1'b1,8'h07,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b0,1'b0,9'h081,1'b0,8'h81,1'b0,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b0,1'b0,9'h000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,1'b0,9'h000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,1'b0,9'h100,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b1,1'b1,1'b0,9'h000,1'b0,8'h00,1'b0,1'b1,1'b1,1'b1},
      '{1'b0,1'b1,1'b0,1'b0,9'h000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1},
      '{1'b0,1'b0,1'b0,1'b0,9'h000,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0},
      '{1'b1,1'b1,1'b0,1'b1,9'h101,1'b1,8'h01,1'b1,1'b0,1'b1,1'b0}
   };

   // packed view: {full, data[7:0], bit8, fe, pe, ov, nf, brk}
   function automatic logic [14:0] obs();
      return {rx_full, rx_data, rx_bit8, err_frame, err_parity, err_overrun, err_noise, brk_flag};
   endfunction

   task automatic chk(input string req, input logic [14:0] exp);
      logic [14:0] act;
      act = obs();
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tk(input logic v);
      @(negedge clk);
      rx_line = v;
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
   endtask

   task automatic send_bit(input logic v, input int glitch);
      for (int t = 1; t <= 16; t++) tk((t == glitch) ? !v : v);
   endtask

   // gbit: data bit index carrying a one-tick glitch at tick gtick (-1: none)
   task automatic send_frame(input logic nine, input logic pen, input logic parbit,
                             input logic [8:0] dat, input logic stop,
                             input int gbit, input int gtick, input bit trail_hi);
      send_bit(1'b0, 0);
      for (int i = 0; i < (nine ? 9 : 8); i++) send_bit(dat[i], (i == gbit) ? gtick : 0);
      if (pen) send_bit(parbit, 0);
      send_bit(stop, 0);
      if (trail_hi) send_bit(1'b1, 0);
   endtask

   task automatic clear();
      @(negedge clk);
      clr_strobe = 1'b1;
      @(negedge clk);
      clr_strobe = 1'b0;
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         report();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; os_tick = 1'b0; rx_line = 1'b1; clr_strobe = 1'b0;
      cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 reset", 15'h0);
      rst_n = 1'b1;
      send_bit(1'b1, 0);
      send_bit(1'b1, 0);
      chk("R10 idle after reset", 15'h0);

      // table walk
      for (int k = 0; k < NV; k++) begin
         vec_t v;
         string tag;
         v = VECS[k];
         cfg_nine = v.nine; cfg_par_en = v.pen; cfg_par_odd = v.podd;
         send_frame(v.nine, v.pen, v.parbit, v.dat, v.stop, -1, 0, 1'b1);
         if (v.e_brk)     tag = "R5 break";
         else if (v.e_fe) tag = "R4 framing";
         else if (v.pen)  tag = "R6 parity";
         else             tag = "R1 data";
         chk($sformatf("%s vec %0d", tag, k),
             {1'b1, v.e_dat, v.e_r8, v.e_fe, v.e_pe, 1'b0, 1'b0, v.e_brk});
         clear();
      end
      cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
      chk("R8 clear after table", {1'b1 ^ 1'b1, 8'h00, 1'b1, 5'b0} & 15'h0 | {1'b0, rx_data, rx_bit8, 5'b0});

      // R2: glitch inside the sampling window
      send_frame(1'b0, 1'b0, 1'b0, 9'h05A, 1'b1, 3, 9, 1'b1);
      chk("R2 glitch in window", {1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
      clear();
      // R2: glitch outside the sampling window
      send_frame(1'b0, 1'b0, 1'b0, 9'h05A, 1'b1, 3, 3, 1'b1);
      chk("R2 glitch outside window", {1'b1, 8'h5A, 1'b0, 5'b0});
      clear();

      // R3: short low pulse
      for (int t = 0; t < 4; t++) tk(1'b0);
      send_bit(1'b1, 0);
      send_bit(1'b1, 0);
      chk("R3 false start ignored", {1'b0, 8'h5A, 1'b0, 5'b0});
      send_frame(1'b0, 1'b0, 1'b0, 9'h03C, 1'b1, -1, 0, 1'b1);
      chk("R3 frame after false start", {1'b1, 8'h3C, 1'b0, 5'b0});

      // R7: second character while full
      clear();
      send_frame(1'b0, 1'b0, 1'b0, 9'h011, 1'b1, -1, 0, 1'b1);
      send_frame(1'b0, 1'b0, 1'b0, 9'h022, 1'b0, -1, 0, 1'b1);
      chk("R7 overrun keeps data", {1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

      // R8: acknowledge clears full and flags, data kept
      clear();
      chk("R8 clear", {1'b0, 8'h11, 1'b0, 5'b0});

      // R9: line held low after a break
      send_frame(1'b0, 1'b0, 1'b0, 9'h000, 1'b0, -1, 0, 1'b0);
      chk("R9 break seen", {1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
      clear();
      for (int b = 0; b < 20; b++) send_bit(1'b0, 0);
      chk("R9 held low gives nothing", {1'b0, 8'h00, 1'b0, 5'b0});
      send_bit(1'b1, 0);
      send_frame(1'b0, 1'b0, 1'b0, 9'h066, 1'b1, -1, 0, 1'b1);
      chk("R9 frame after line high", {1'b1, 8'h66, 1'b0, 5'b0});

      finished = 1'b1;
      report();
      $finish;
   end

endmodule